// File: doc/BRIEF.md
# JTAG Flash Access Controller

This block gives a scan path direct access to an on-chip flash array while the processor core sits idle. A test access port, outside this block, shifts words in and out. The block sees each completed shift as a parallel word with an update strobe, or as a capture strobe that asks for a word to return. The word goes to one of three registers, picked by a select code: a control/status register, an address register and a data register. From those registers the block drives a simple flash port. The port has address, write data, read data, one-cycle read, program and erase strobes, and a busy input from the flash.

While access is on, the block holds the chip reset output asserted with clocks still running, so neither core nor host can touch the flash. Access can only be switched on in two of the four environment codes. An external protection input limits which operations are allowed: reads return nothing, programs are refused, and a full-array erase is the only way out. A blank indication keeps the core in reset after access ends. The address register steps by one after every program and every read capture, so a whole image can be streamed with one address load.

Top module: `jtag_flash_ctl`

## Requirements
- R1: A control write with bit 0 set switches access on only when bit 1 of `env_mode` is 0 (codes 00 and 01). Under codes 10 and 11 the write leaves access off. Writing bit 0 clear switches access off in any environment.
- R2: Control layout: bits DW-1:DW-2 hold the operation (00 none, 01 program, 10 read, 11 erase), bit 2 is the error flag, bit 1 is busy and bit 0 is access-enable. The enable bit is written only when the written operation field is 00, so scanning 16'h8000 selects read and leaves access on. A status capture returns {op, zeros, error, busy, enable}.
- R3: One cycle after access is switched on, `chip_rst` is asserted, and it stays asserted for as long as access is on.
- R4: Busy reads 1 from the write that switches access on until `chip_rst` is in effect, and also while the flash reports busy or a read, program or erase transfer is in flight.
- R5: The address register is loaded by an address update. It advances by one after each accepted program and each accepted read capture, and wraps from 2^AW-1 to 0.
- R6: Flash operations are issued only while access is on and `chip_rst` is in effect. With the program operation selected, a data update writes that word to the flash at the current address.
- R7: With the read operation selected, an address update fetches the word at that address. The word reaches the data register two cycles after the update. A data capture returns it, then advances the address and fetches the next word.
- R8: While `prot_on` is 1, a data capture returns 0, and a program data update issues no program strobe. Neither of these advances the address, and both set the error flag.
- R9: A control write with operation 11 while access is on issues one erase strobe for the whole array, even while `prot_on` is 1.
- R10: The error flag is cleared by a control write with bit 2 set. A refused operation in the same cycle wins and keeps the flag set.
- R11: When access is switched off, `chip_rst` is released one cycle later. If `blank_flag` is 1, `chip_rst` stays asserted.
- R12: While `rst` is high, `chip_rst` is asserted and all three registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| scan_upd | input | 1 | Update strobe: load `scan_din` into the selected register |
| scan_cap | input | 1 | Capture strobe: return the selected register on `scan_dout` |
| scan_din | input | DW | Word shifted in |
| scan_dout | output | DW | Captured word, registered |
| env_mode | input | 2 | Environment code |
| prot_on | input | 1 | Content protection active |
| blank_flag | input | 1 | Flash holds no valid code |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash program data |
| fl_rdata | input | DW | Flash read data, one cycle after `fl_rd` |
| fl_rd | output | 1 | Read strobe |
| fl_wr | output | 1 | Program strobe |
| fl_erase | output | 1 | Full-array erase strobe |
| fl_busy | input | 1 | Flash operation in progress |
| chip_rst | output | 1 | Chip reset request |

## Verification
A wrong address count shows up in every later read of a full-array sweep. It is seen as a data mismatch at the first capture after the fault, and an address capture after the sweep exposes a missing wrap. A wrong enable or reset state appears on `chip_rst` within one cycle of the control write. A wrong busy term is caught by the status capture that follows the enable or erase write. Under protection, a leaked strobe shows up as a changed word when the address is read back after protection is lifted, and a leaked read shows up at once as a nonzero capture.

// File: rtl/jfc_pkg.sv
package jfc_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_PROG  = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2
  } sel_e;

  localparam int EN_BIT   = 0;
  localparam int BUSY_BIT = 1;
  localparam int ERR_BIT  = 2;
endpackage

// File: rtl/jfc_ctl_reg.sv
module jfc_ctl_reg
  import jfc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    env_i,
  input  logic          blank_i,
  input  logic          path_busy_i,
  input  logic          refuse_i,
  output logic          en_o,
  output op_e           op_o,
  output logic          err_o,
  output logic          busy_o,
  output logic          chip_rst_o
);
  logic en_q, err_q, chip_rst_q;
  op_e  op_q;
  op_e  wop;
  logic env_ok;

  assign wop    = op_e'(wdata_i[DW-1 -: 2]);
  assign env_ok = ~env_i[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      op_q       <= OP_NONE;
      err_q      <= 1'b0;
      chip_rst_q <= 1'b1;
    end else begin
      if (wr_i && wop == OP_NONE && (env_ok || !wdata_i[EN_BIT]))
        en_q <= wdata_i[EN_BIT];
      if (wr_i)
        op_q <= wop;
      if (refuse_i)
        err_q <= 1'b1;
      else if (wr_i && wdata_i[ERR_BIT])
        err_q <= 1'b0;
      chip_rst_q <= en_q | blank_i;
    end
  end

  assign en_o       = en_q;
  assign op_o       = op_q;
  assign err_o      = err_q;
  assign chip_rst_o = chip_rst_q;
  assign busy_o     = en_q & (~chip_rst_q | path_busy_i);

  // R1
  env_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && env_i[1] && !en_q) |=> !en_q);
  // R3
  rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> chip_rst_q);
  // R11
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    blank_i |=> chip_rst_q);
  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    refuse_i |=> err_q);
endmodule

// File: rtl/jfc_addr_reg.sv
module jfc_addr_reg #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (inc_i)  addr_q <= addr_q + AW'(1);
  end

  assign addr_o = addr_q;

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i) |=> (addr_q == $past(addr_q) + AW'(1)));
endmodule

// File: rtl/jfc_datapath.sv
module jfc_datapath
  import jfc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active_i,
  input  op_e           op_i,
  input  logic          prot_i,
  input  logic          wr_ctl_i,
  input  logic          wr_addr_i,
  input  logic          wr_data_i,
  input  logic          cap_data_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] fl_rdata_i,
  input  logic          fl_busy_i,
  output logic [DW-1:0] data_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_wdata_o,
  output logic          fl_rd_o,
  output logic          fl_wr_o,
  output logic          fl_erase_o,
  output logic          inc_o,
  output logic          refuse_o,
  output logic          busy_o
);
  logic rd_mode, pg_mode;
  logic rd_from_addr, rd_from_cap, pg_go, erase_go;
  logic fl_rd_q, fl_wr_q, fl_erase_q, rd_wait_q;
  logic [AW-1:0] fl_addr_q;
  logic [DW-1:0] fl_wdata_q, data_q;

  always_comb begin
    rd_mode      = active_i && op_i == OP_READ;
    pg_mode      = active_i && op_i == OP_PROG;
    rd_from_addr = rd_mode && wr_addr_i && !prot_i;
    rd_from_cap  = rd_mode && cap_data_i && !prot_i;
    pg_go        = pg_mode && wr_data_i && !prot_i;
    erase_go     = active_i && wr_ctl_i && (op_e'(wdata_i[DW-1 -: 2]) == OP_ERASE);
    refuse_o     = prot_i && ((rd_mode && cap_data_i) || (pg_mode && wr_data_i));
    inc_o        = rd_from_cap || pg_go;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_rd_q    <= 1'b0;
      fl_wr_q    <= 1'b0;
      fl_erase_q <= 1'b0;
      rd_wait_q  <= 1'b0;
      fl_addr_q  <= '0;
      fl_wdata_q <= '0;
      data_q     <= '0;
    end else begin
      fl_rd_q    <= rd_from_addr | rd_from_cap;
      fl_wr_q    <= pg_go;
      fl_erase_q <= erase_go;
      rd_wait_q  <= fl_rd_q;
      if (rd_from_addr)     fl_addr_q <= wdata_i[AW-1:0];
      else if (rd_from_cap) fl_addr_q <= addr_i + AW'(1);
      else if (pg_go)       fl_addr_q <= addr_i;
      if (pg_go)            fl_wdata_q <= wdata_i;
      if (wr_data_i)        data_q <= wdata_i;
      else if (rd_wait_q)   data_q <= fl_rdata_i;
    end
  end

  assign data_o     = data_q;
  assign fl_addr_o  = fl_addr_q;
  assign fl_wdata_o = fl_wdata_q;
  assign fl_rd_o    = fl_rd_q;
  assign fl_wr_o    = fl_wr_q;
  assign fl_erase_o = fl_erase_q;
  assign busy_o     = fl_busy_i | fl_rd_q | rd_wait_q | fl_wr_q | fl_erase_q;

  // R8
  prot_prog_chk: assert property (@(posedge clk) disable iff (rst)
    fl_wr_q |-> !$past(prot_i));
  // R8
  prot_read_chk: assert property (@(posedge clk) disable iff (rst)
    fl_rd_q |-> !$past(prot_i));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fl_rd_q, fl_wr_q, fl_erase_q}));
  // R7
  fill_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_wait_q && !wr_data_i) |=> (data_q == $past(fl_rdata_i)));
endmodule

// File: rtl/jtag_flash_ctl.sv
module jtag_flash_ctl
  import jfc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    scan_sel,
  input  logic          scan_upd,
  input  logic          scan_cap,
  input  logic [DW-1:0] scan_din,
  output logic [DW-1:0] scan_dout,
  input  logic [1:0]    env_mode,
  input  logic          prot_on,
  input  logic          blank_flag,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          fl_rd,
  output logic          fl_wr,
  output logic          fl_erase,
  input  logic          fl_busy,
  output logic          chip_rst
);
  localparam int PADW = DW - 5;
  localparam int APAD = DW - AW;

  logic wr_ctl, wr_addr, wr_data, cap_data;
  logic en, err, busy, chip_rst_w, path_busy, refuse, inc;
  op_e  op;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic [DW-1:0] cap_q;

  assign wr_ctl   = scan_upd && sel_e'(scan_sel) == SEL_CTL;
  assign wr_addr  = scan_upd && sel_e'(scan_sel) == SEL_ADDR;
  assign wr_data  = scan_upd && sel_e'(scan_sel) == SEL_DATA;
  assign cap_data = scan_cap && sel_e'(scan_sel) == SEL_DATA;

  jfc_ctl_reg #(.DW(DW)) u_ctl (
    .clk(clk), .rst(rst), .wr_i(wr_ctl), .wdata_i(scan_din),
    .env_i(env_mode), .blank_i(blank_flag), .path_busy_i(path_busy),
    .refuse_i(refuse), .en_o(en), .op_o(op), .err_o(err),
    .busy_o(busy), .chip_rst_o(chip_rst_w)
  );

  jfc_addr_reg #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load_i(wr_addr), .load_val_i(scan_din[AW-1:0]),
    .inc_i(inc), .addr_o(addr)
  );

  jfc_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .active_i(en & chip_rst_w), .op_i(op),
    .prot_i(prot_on), .wr_ctl_i(wr_ctl), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cap_data_i(cap_data), .wdata_i(scan_din),
    .addr_i(addr), .fl_rdata_i(fl_rdata), .fl_busy_i(fl_busy),
    .data_o(data), .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata),
    .fl_rd_o(fl_rd), .fl_wr_o(fl_wr), .fl_erase_o(fl_erase),
    .inc_o(inc), .refuse_o(refuse), .busy_o(path_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else if (scan_cap) begin
      unique case (sel_e'(scan_sel))
        SEL_CTL:  cap_q <= {op, {PADW{1'b0}}, err, busy, en};
        SEL_ADDR: cap_q <= {{APAD{1'b0}}, addr};
        SEL_DATA: cap_q <= prot_on ? '0 : data;
        default:  cap_q <= '0;
      endcase
    end
  end

  assign scan_dout = cap_q;
  assign chip_rst  = chip_rst_w;
endmodule

// File: tb/tb_jtag_flash_ctl.sv
module tb_jtag_flash_ctl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] scan_sel = 2'd0;
  logic scan_upd = 1'b0, scan_cap = 1'b0;
  logic [DW-1:0] scan_din = '0;
  logic [DW-1:0] scan_dout;
  logic [1:0] env_mode = 2'd0;
  logic prot_on = 1'b0, blank_flag = 1'b0;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;
  logic fl_rd, fl_wr, fl_erase, fl_busy;
  logic chip_rst;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  jtag_flash_ctl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .scan_sel(scan_sel), .scan_upd(scan_upd),
    .scan_cap(scan_cap), .scan_din(scan_din), .scan_dout(scan_dout),
    .env_mode(env_mode), .prot_on(prot_on), .blank_flag(blank_flag),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_erase(fl_erase), .fl_busy(fl_busy),
    .chip_rst(chip_rst)
  );

  // behavioural flash: one-cycle read, busy window after program/erase
  logic [DW-1:0] mem [0:NW-1];
  logic [2:0] bcnt;
  always_ff @(posedge clk) begin
    if (fl_rd) fl_rdata <= mem[fl_addr];
    if (rst) bcnt <= '0;
    else if (fl_wr) begin
      mem[fl_addr] <= fl_wdata;
      bcnt <= 3'd3;
    end else if (fl_erase) begin
      for (int k = 0; k < NW; k++) mem[k] <= '1;
      bcnt <= 3'd5;
    end else if (bcnt != 0) bcnt <= bcnt - 3'd1;
  end
  assign fl_busy = (bcnt != 0);

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 97 + 16'h1234) ^ (a << 8));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic upd(input logic [1:0] s, input logic [15:0] v);
    scan_sel = s; scan_din = v; scan_upd = 1'b1;
    @(negedge clk);
    scan_upd = 1'b0;
  endtask

  task automatic cap(input logic [1:0] s, output logic [15:0] v);
    scan_sel = s; scan_cap = 1'b1;
    @(negedge clk);
    scan_cap = 1'b0;
    v = scan_dout;
  endtask

  task automatic wait_idle();
    logic [15:0] st;
    for (int n = 0; n < 64; n++) begin
      cap(2'd0, st);
      if (!st[1]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    chk("R12 chip_rst in reset", {15'd0, chip_rst}, 16'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 chip_rst after reset", {15'd0, chip_rst}, 16'd0);
    cap(2'd0, v); chk("R12 ctl reset", v, 16'h0000);
    cap(2'd1, v); chk("R12 addr reset", v, 16'h0000);
    cap(2'd2, v); chk("R12 data reset", v, 16'h0000);

    // R1 environment sweep
    for (int e = 0; e < 4; e++) begin
      env_mode = 2'(e);
      upd(2'd0, 16'h0001);
      cap(2'd0, v);
      chk("R1 enable gating", {15'd0, v[0]}, {15'd0, (e < 2)});
      upd(2'd0, 16'h0000);
      @(negedge clk);
      @(negedge clk);
    end

    // R3 R4 enable sequence
    env_mode = 2'd1;
    upd(2'd0, 16'h0001);
    cap(2'd0, v);
    chk("R4 busy after enable", {15'd0, v[1]}, 16'd1);
    chk("R3 chip_rst asserted", {15'd0, chip_rst}, 16'd1);
    wait_idle();
    cap(2'd0, v);
    chk("R4 busy clears", v, 16'h0001);

    // R6 R5 program whole array
    upd(2'd0, 16'h4000);
    upd(2'd1, 16'h0000);
    for (int a = 0; a < NW; a++) begin
      upd(2'd2, pat(a));
      if (a == 0) begin
        cap(2'd1, v); chk("R5 step after program", v, 16'h0001);
      end
      wait_idle();
    end
    cap(2'd1, v); chk("R5 wrap after program", v, 16'h0000);

    // R2 R7 read sweep
    upd(2'd0, 16'h8000);
    cap(2'd0, v); chk("R2 read code keeps enable", v, 16'h8001);
    upd(2'd1, 16'h0000);
    wait_idle();
    for (int a = 0; a < NW; a++) begin
      cap(2'd2, v);
      chk("R7 read data", v, pat(a));
      wait_idle();
    end
    cap(2'd1, v); chk("R5 wrap after read", v, 16'h0000);

    // R8 R10 protection
    prot_on = 1'b1;
    upd(2'd1, 16'h0005);
    wait_idle();
    cap(2'd2, v); chk("R8 protected read", v, 16'h0000);
    cap(2'd0, v); chk("R8 error set", v, 16'h8005);
    cap(2'd1, v); chk("R8 no step on refused read", v, 16'h0005);
    upd(2'd0, 16'h8004);
    cap(2'd0, v); chk("R10 error cleared", v, 16'h8001);
    upd(2'd0, 16'h4000);
    upd(2'd1, 16'h0007);
    upd(2'd2, 16'hDEAD);
    wait_idle();
    cap(2'd1, v); chk("R8 no step on refused program", v, 16'h0007);
    cap(2'd0, v); chk("R8 error after program", v, 16'h4005);
    upd(2'd0, 16'h4004);
    prot_on = 1'b0;
    upd(2'd0, 16'h8000);
    upd(2'd1, 16'h0007);
    wait_idle();
    cap(2'd2, v); chk("R8 word unchanged", v, pat(7));
    wait_idle();

    // R9 erase under protection
    prot_on = 1'b1;
    upd(2'd0, 16'hC000);
    cap(2'd0, v); chk("R4 busy during erase", {15'd0, v[1]}, 16'd1);
    wait_idle();
    prot_on = 1'b0;
    upd(2'd0, 16'h8000);
    upd(2'd1, 16'h0009);
    wait_idle();
    cap(2'd2, v); chk("R9 erased word", v, 16'hFFFF);
    wait_idle();

    // R11 release and blank hold
    upd(2'd0, 16'h0000);
    chk("R11 chip_rst one cycle", {15'd0, chip_rst}, 16'd1);
    @(negedge clk);
    chk("R11 chip_rst released", {15'd0, chip_rst}, 16'd0);
    blank_flag = 1'b1;
    upd(2'd0, 16'h0001);
    wait_idle();
    upd(2'd0, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R11 blank holds reset", {15'd0, chip_rst}, 16'd1);
    blank_flag = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 release after blank", {15'd0, chip_rst}, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule